// File: doc/BRIEF.md
# Rail Fault Supervisor with Latch-Off

This block decides when every power output of a supply controller must be switched off. It watches three kinds of digitized evidence. The first is a per-rail "output below 80 % of nominal" flag. The second is a pair of threshold comparator levels for each of two supplies (standby and main). The third is a die over-temperature flag. From these it drives a single global output-disable.

Short undervoltage glitches are tolerated. A rail that stays low for a programmable number of consecutive clock cycles is treated as shorted. That rail's fault latches and holds the outputs off until standby power goes away and comes back. Supply lockout and thermal shutdown are different: they release by themselves once their inputs recover.

Rail monitoring is suspended in three cases:
- while soft-start is running;
- for the memory rail while that rail is deliberately switched off in the deep-sleep state;
- while the outputs are already forced off by a lockout or by thermal shutdown.

A status word reports each latched rail fault and each non-latching shutdown cause.

Top module: `rail_fault_supervisor`

## Requirements
- R1: While reset is applied, and after it is released with all inputs low, no rail fault is latched. Both supply-lockout bits are set and `outputs_off` is 1.
- R2: Each supply has a lockout with hysteresis. A locked supply is released on the first clock edge that samples its rising-threshold input at 1. A released supply stays released until an edge samples its falling-threshold input at 0. The two supplies are independent.
- R3: A rail's fault latches on the clock edge that completes `DELAY_CYC` consecutive edges with its undervoltage flag high and the rail unmasked. One edge fewer does not latch.
- R4: If an undervoltage flag is low, or the rail is masked, on any edge before the count completes, that rail's count restarts from zero.
- R5: A latched fault holds through any input activity, including while `stby_pgood` is low. It clears on the first edge that sees `stby_pgood` high after an edge that saw it low.
- R6: While `soft_start` is 1, no rail counts and no rail fault can latch.
- R7: While `mem_rail_off` is 1, the rail at index `MEM_RAIL_IDX` is masked. The other rails keep counting normally.
- R8: Over-temperature is non-latching. `outputs_off` and its status bit are 1 starting one edge after `die_hot` is sampled 1, and return to 0 one edge after it is sampled 0.
- R9: `outputs_off` is 1 exactly when any rail fault is latched, either supply is locked out, or the registered over-temperature is set. While a lockout or over-temperature is active, rail counting is suspended.
- R10: `fault_status` layout:
  - bits `[NUM_RAILS-1:0]` hold the latched fault of each rail;
  - bit `NUM_RAILS` is the standby lockout;
  - bit `NUM_RAILS+1` is the main lockout;
  - bit `NUM_RAILS+2` is over-temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rail_uv | input | NUM_RAILS | Per-rail flag: output below 80 % of nominal |
| mem_rail_off | input | 1 | Memory rail intentionally off (deep sleep) |
| soft_start | input | 1 | Soft-start ramp in progress |
| stby_rise_ok | input | 1 | Standby supply above its turn-on threshold |
| stby_fall_ok | input | 1 | Standby supply above its turn-off threshold |
| main_rise_ok | input | 1 | Main supply above its turn-on threshold |
| main_fall_ok | input | 1 | Main supply above its turn-off threshold |
| die_hot | input | 1 | Die temperature above the shutdown limit |
| stby_pgood | input | 1 | Standby power good; a low-then-high cycle clears latched faults |
| outputs_off | output | 1 | Global disable of all power outputs |
| fault_status | output | NUM_RAILS+3 | Latched rail faults and shutdown causes (layout in R10) |

## Verification
Directed patterns check the qualification boundary on the trip counter:
- a flag held exactly one edge short of the delay;
- a flag held for the full delay;
- a flag held with a single low edge in the middle, which tells a restarting counter apart from an accumulating one.

Masking is tried in each of its three contexts. Soft-start, memory-rail-off and active lockout are each held longer than the delay. The memory-rail case runs alongside an unmasked rail, which shows the mask applies to one index only.

Constrained random sequences then mix sticky undervoltage flags with occasional lockouts, thermal events and power-good cycles. A cycle-level expectation model checks every cycle.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Offsets of the shutdown-cause bits above the per-rail fault bits.
  localparam int unsigned STAT_STBY_OFS = 0;
  localparam int unsigned STAT_MAIN_OFS = 1;
  localparam int unsigned STAT_HOT_OFS  = 2;
  localparam int unsigned STAT_EXTRA    = 3;

  function automatic int unsigned status_width(input int unsigned nrails);
    return nrails + STAT_EXTRA;
  endfunction

endpackage

// File: rtl/fsup_rst_sync.sv
module fsup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/fsup_hyst_lockout.sv
module fsup_hyst_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic above_rise,
  input  logic above_fall,
  output logic lockout
);

  logic ok_q;
  logic ok_d;

  // Next state: a released supply follows the falling threshold,
  // a locked supply follows the rising threshold.
  always_comb begin
    if (ok_q) begin
      ok_d = above_fall;
    end else begin
      ok_d = above_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
    end else begin
      ok_q <= ok_d;
    end
  end

  assign lockout = ~ok_q;

  // R2: a locked supply without its rising threshold stays locked
  a_r2_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !above_rise) |=> lockout);

  // R2: a released supply above its falling threshold stays released
  a_r2_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout && above_fall) |=> !lockout);

endmodule

// File: rtl/fsup_rail_trip.sv
module fsup_rail_trip #(
  parameter int unsigned DELAY_CYC = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag,
  input  logic mask,
  input  logic clear,
  output logic tripped
);

  localparam int unsigned CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          trip_q;
  logic          trip_d;
  logic          active;

  assign active = uv_flag & ~mask;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (clear) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (!active || trip_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      trip_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign tripped = trip_q;

  // R3: a trip can only come from an unmasked, flagged cycle
  a_r3_trip_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(uv_flag && !mask));

  // R5: a latched fault holds until the power-cycle clear
  a_r5_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !clear) |=> tripped);

  // R6, R7: a masked rail never trips on that edge
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !tripped) |=> !tripped);

endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned NUM_RAILS    = 3,
  parameter int unsigned DELAY_CYC    = 30000,
  parameter int unsigned MEM_RAIL_IDX = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_RAILS-1:0]              rail_uv,
  input  logic                              mem_rail_off,
  input  logic                              soft_start,
  input  logic                              stby_rise_ok,
  input  logic                              stby_fall_ok,
  input  logic                              main_rise_ok,
  input  logic                              main_fall_ok,
  input  logic                              die_hot,
  input  logic                              stby_pgood,
  output logic                              outputs_off,
  output logic [status_width(NUM_RAILS)-1:0] fault_status
);

  logic                 rst_int_n;
  logic                 stby_lock;
  logic                 main_lock;
  logic                 hot_q;
  logic                 pgood_q;
  logic                 pgood_rise;
  logic                 suspend;
  logic [NUM_RAILS-1:0] rail_mask;
  logic [NUM_RAILS-1:0] rail_trip;

  fsup_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fsup_hyst_lockout u_stby_lock (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .above_rise (stby_rise_ok),
    .above_fall (stby_fall_ok),
    .lockout    (stby_lock)
  );

  fsup_hyst_lockout u_main_lock (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .above_rise (main_rise_ok),
    .above_fall (main_fall_ok),
    .lockout    (main_lock)
  );

  // Registered thermal flag and power-good history.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hot_q   <= 1'b0;
      pgood_q <= 1'b0;
    end else begin
      hot_q   <= die_hot;
      pgood_q <= stby_pgood;
    end
  end

  assign pgood_rise = stby_pgood & ~pgood_q;
  assign suspend    = stby_lock | main_lock | hot_q;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    if (i == MEM_RAIL_IDX) begin : g_mem
      assign rail_mask[i] = soft_start | suspend | mem_rail_off;
    end else begin : g_std
      assign rail_mask[i] = soft_start | suspend;
    end

    fsup_rail_trip #(
      .DELAY_CYC (DELAY_CYC)
    ) u_trip (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .uv_flag (rail_uv[i]),
      .mask    (rail_mask[i]),
      .clear   (pgood_rise),
      .tripped (rail_trip[i])
    );
  end

  assign outputs_off = (|rail_trip) | suspend;
  assign fault_status = {hot_q, main_lock, stby_lock, rail_trip};

  // R9: any latched rail fault forces the outputs off
  a_r9_trip_disables: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|rail_trip) |-> outputs_off);

  // R8: a hot die turns outputs off on the following edge
  a_r8_hot_disables: assert property (@(posedge clk) disable iff (!rst_int_n)
    die_hot |=> outputs_off);

  // R5: a power-good rise clears every latched fault
  a_r5_cycle_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stby_pgood && !pgood_q) |=> (rail_trip == '0));

  // R6: soft-start prevents any new fault from latching
  a_r6_softstart_no_trip: assert property (@(posedge clk) disable iff (!rst_int_n)
    soft_start |=> !$rose(|rail_trip));

endmodule

// File: tb/rail_fault_supervisor_test.sv
module rail_fault_supervisor_test;

  localparam int NR  = 3;
  localparam int DLY = 12;
  localparam int MEM = 2;
  localparam int SW  = NR + 3;

  logic          clk;
  logic          rst_n;
  logic [NR-1:0] rail_uv;
  logic          mem_rail_off;
  logic          soft_start;
  logic          stby_rise_ok;
  logic          stby_fall_ok;
  logic          main_rise_ok;
  logic          main_fall_ok;
  logic          die_hot;
  logic          stby_pgood;
  logic          outputs_off;
  logic [SW-1:0] fault_status;

  int nchk;
  int nfail;
  bit done;

  // Expectation model state
  bit m_sok, m_mok, m_hot, m_pg;
  bit [NR-1:0] m_lat;
  int m_cnt [NR];

  rail_fault_supervisor #(
    .NUM_RAILS    (NR),
    .DELAY_CYC    (DLY),
    .MEM_RAIL_IDX (MEM)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rail_uv      (rail_uv),
    .mem_rail_off (mem_rail_off),
    .soft_start   (soft_start),
    .stby_rise_ok (stby_rise_ok),
    .stby_fall_ok (stby_fall_ok),
    .main_rise_ok (main_rise_ok),
    .main_fall_ok (main_fall_ok),
    .die_hot      (die_hot),
    .stby_pgood   (stby_pgood),
    .outputs_off  (outputs_off),
    .fault_status (fault_status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_status();
    return {m_hot, ~m_mok, ~m_sok, m_lat};
  endfunction

  function automatic logic exp_off();
    return (|m_lat) | ~m_sok | ~m_mok | m_hot;
  endfunction

  task automatic model_step();
    bit clr;
    bit susp;
    bit act;
    clr  = stby_pgood && !m_pg;
    susp = !m_sok || !m_mok || m_hot;
    for (int i = 0; i < NR; i++) begin
      act = rail_uv[i] && !soft_start && !(i == MEM && mem_rail_off) && !susp;
      if (clr) begin
        m_lat[i] = 1'b0;
        m_cnt[i] = 0;
      end else if (!act || m_lat[i]) begin
        m_cnt[i] = 0;
      end else if (m_cnt[i] == DLY - 1) begin
        m_lat[i] = 1'b1;
        m_cnt[i] = 0;
      end else begin
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    m_sok = m_sok ? stby_fall_ok : stby_rise_ok;
    m_mok = m_mok ? main_fall_ok : main_rise_ok;
    m_hot = die_hot;
    m_pg  = stby_pgood;
  endtask

  // One clock: advance model, pass an edge, compare at the falling edge.
  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk("R10 status vs model", fault_status, exp_status());
      chk("R9 outputs_off vs model", outputs_off, exp_off());
    end
  endtask

  task automatic power_cycle();
    rail_uv    = '0;
    stby_pgood = 1'b0;
    step();
    stby_pgood = 1'b1;
    step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    int unsigned r;
    seed = 32'd918273;
    r = $urandom(seed);
    nchk = 0;
    nfail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    rail_uv = '0;
    mem_rail_off = 1'b0;
    soft_start = 1'b0;
    stby_rise_ok = 1'b0;
    stby_fall_ok = 1'b0;
    main_rise_ok = 1'b0;
    main_fall_ok = 1'b0;
    die_hot = 1'b0;
    stby_pgood = 1'b0;
    m_sok = 0; m_mok = 0; m_hot = 0; m_pg = 0; m_lat = '0;
    for (int i = 0; i < NR; i++) m_cnt[i] = 0;

    repeat (3) @(negedge clk);
    chk("R1 status in reset", fault_status, 6'b011000);
    chk("R1 outputs_off in reset", outputs_off, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 status after release", fault_status, 6'b011000);
    chk("R1 outputs_off after release", outputs_off, 1'b1);

    // R2 hysteresis on both supplies
    stby_rise_ok = 1'b1; stby_fall_ok = 1'b1;
    step();
    chk("R2 standby released, main locked", fault_status, 6'b010000);
    main_rise_ok = 1'b1; main_fall_ok = 1'b1;
    step();
    chk("R2 both released", fault_status, 6'b000000);
    chk("R2 outputs on", outputs_off, 1'b0);
    stby_rise_ok = 1'b0; main_rise_ok = 1'b0;
    step(2);
    chk("R2 released holds without rising input", fault_status, 6'b000000);
    stby_fall_ok = 1'b0;
    step();
    chk("R2 standby relocks on falling input", fault_status, 6'b001000);
    stby_fall_ok = 1'b1;
    step();
    chk("R2 locked holds without rising input", fault_status, 6'b001000);
    stby_rise_ok = 1'b1; main_rise_ok = 1'b1;
    step();
    chk("R2 standby released again", fault_status, 6'b000000);
    stby_pgood = 1'b1;
    step();

    // R3 delay boundary
    rail_uv[0] = 1'b1;
    step(DLY - 1);
    chk("R3 no trip one edge short", fault_status, 6'b000000);
    step();
    chk("R3 trip at full delay", fault_status, 6'b000001);
    chk("R3 outputs off on trip", outputs_off, 1'b1);

    // R5 hold and power-cycle clear
    rail_uv = '0;
    step(3);
    chk("R5 latch holds after flag clears", fault_status, 6'b000001);
    stby_pgood = 1'b0;
    step();
    chk("R5 latch holds while pgood low", fault_status, 6'b000001);
    stby_pgood = 1'b1;
    step();
    chk("R5 latch cleared after pgood rise", fault_status, 6'b000000);

    // R4 counter restart
    rail_uv[1] = 1'b1;
    step(DLY - 1);
    rail_uv[1] = 1'b0;
    step();
    rail_uv[1] = 1'b1;
    step(DLY - 1);
    chk("R4 interrupted flag does not trip", fault_status, 6'b000000);
    step();
    chk("R4 trip after full restarted count", fault_status, 6'b000010);
    power_cycle();

    // R6 soft-start masking
    soft_start = 1'b1;
    rail_uv[0] = 1'b1;
    step(DLY + 3);
    chk("R6 no trip during soft-start", fault_status, 6'b000000);
    soft_start = 1'b0;
    step(DLY - 1);
    chk("R6 count starts after soft-start", fault_status, 6'b000000);
    step();
    chk("R6 trip after soft-start ends", fault_status, 6'b000001);
    power_cycle();

    // R7 memory-rail masking only on its index
    mem_rail_off = 1'b1;
    rail_uv[2] = 1'b1;
    rail_uv[0] = 1'b1;
    step(DLY);
    chk("R7 other rail trips, memory rail masked", fault_status, 6'b000001);
    step(3);
    chk("R7 memory rail stays masked", fault_status, 6'b000001);
    power_cycle();
    mem_rail_off = 1'b0;
    rail_uv[2] = 1'b1;
    step(DLY);
    chk("R7 memory rail trips when on", fault_status, 6'b000100);
    power_cycle();

    // R8 thermal, non-latching
    die_hot = 1'b1;
    step();
    chk("R8 hot status", fault_status, 6'b100000);
    chk("R8 hot disables", outputs_off, 1'b1);
    die_hot = 1'b0;
    step();
    chk("R8 hot self-clears", fault_status, 6'b000000);
    chk("R8 outputs back on", outputs_off, 1'b0);

    // R9 lockout suspends counting
    stby_fall_ok = 1'b0;
    step();
    stby_fall_ok = 1'b1;
    rail_uv[0] = 1'b1;
    stby_rise_ok = 1'b0;
    step(DLY + 3);
    chk("R9 no trip during lockout", fault_status, 6'b001000);
    stby_rise_ok = 1'b1;
    step();
    step(DLY - 1);
    chk("R9 count restarts after lockout", fault_status, 6'b000000);
    step();
    chk("R9 trip after lockout releases", fault_status, 6'b000001);
    power_cycle();

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NR; i++)
        if (($urandom() % 16) == 0) rail_uv[i] = ~rail_uv[i];
      soft_start   = (($urandom() % 20) == 0);
      mem_rail_off = (($urandom() % 4) == 0);
      die_hot      = (($urandom() % 60) == 0);
      stby_fall_ok = (($urandom() % 80) != 0);
      main_fall_ok = (($urandom() % 80) != 0);
      stby_rise_ok = (($urandom() % 3) == 0);
      main_rise_ok = (($urandom() % 3) == 0);
      stby_pgood   = (($urandom() % 90) != 0);
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule